// File: doc/BRIEF.md
# Bit-Serial CRC-16 Packet Transmitter

This block turns a packet of parallel data words into a single serial bit stream and closes the packet with a 16-bit cyclic redundancy check. Words arrive on a valid/ready handshake. Each accepted word is shifted out one bit per clock, most significant bit first, with a bit-valid strobe. While each data bit leaves, a 16-stage shift register with XOR feedback folds it into the running check value.

After the final data bit of the packet, the 16 check bits follow on the same line with no idle cycle, most significant bit first. A one-cycle completion pulse then marks the end of the packet. A receiver can recompute the check over the data and compare it with the appended value to detect corruption. The check is used only for detection. Nothing is corrected.

A packet ends on the word flagged as last, or on the word that reaches the configured length limit, whichever comes first. The start-of-packet flag restarts the check value and the word count. After every trailer the block returns to the empty state by itself.

Top module: `crc_serial_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `inReady` is 1, `serValid` is 0 and `pktDone` is 0.
- R2: A word accepted on a clock edge where `inValid` and `inReady` are both 1 appears on `serOut` starting in the next cycle. Its bits leave unmodified, one per cycle, bit WORD_W-1 first, with `serValid` high for WORD_W consecutive cycles.
- R3: `inReady` is 0 in every cycle where `serValid` or `pktDone` is 1. A word presented during that time is not taken until `inReady` returns to 1.
- R4: The check value uses the generator x^16 + x^12 + x^5 + 1 (taps 0x1021). It starts from all zeros, takes each data bit in transmit order, and feeds back bit 15 XOR the data bit. For the nine ASCII bytes "123456789" sent as one packet, the trailer is 0x31C3.
- R5: In the cycle right after the final data bit of a packet, the 16 check bits follow with `serValid` high and no gap, bit 15 first.
- R6: `pktDone` is 1 for exactly one cycle: the cycle right after the last check bit. `serValid` is 0 in that cycle.
- R7: A word accepted with `inFirst` = 1 discards the check value and word count built so far. It starts a new packet, even in the middle of one.
- R8: The word that brings the packet to MAX_WORDS words ends the packet and is followed by the trailer, even with `inLast` = 0.
- R9: After a trailer, the next word starts a fresh packet from a zero check value, even without `inFirst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A data word is presented |
| inReady | output | 1 | Block can accept a word this cycle |
| inData | input | WORD_W | Data word |
| inFirst | input | 1 | Presented word opens a new packet |
| inLast | input | 1 | Presented word closes the packet |
| serOut | output | 1 | Serial data or check bit |
| serValid | output | 1 | `serOut` carries a bit this cycle |
| pktDone | output | 1 | One-cycle pulse after the last check bit |

## Verification
The transmitter is driven with several kinds of packet:
- A single-word packet shows bit order and trailer placement in their simplest form.
- The nine-byte ASCII digit string gives a fixed known answer, which separates a wrong polynomial, initial value or bit order from a bench model error.
- A packet restarted midway by the start flag shows whether the earlier check state is really discarded.
- A packet that runs into the length limit without a last flag, followed at once by a packet with no start flag, shows forced termination and the self-clearing of the check value.

Every packet is presented eagerly, with the next word held valid while the previous one is shifting. This separates correct handshaking from early acceptance.

// File: rtl/crc_tx_pkg.sv
package crc_tx_pkg;

  // Strobes from the sequencer to the shifting datapath.
  typedef struct packed {
    logic loadWord;   // capture the presented word
    logic clearCrc;   // zero the check register
    logic shiftData;  // move one data bit out and fold it into the check
    logic shiftCrc;   // move one check bit out
  } crcStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_TRAIL = 2'd2,
    ST_DONE  = 2'd3
  } txState_t;

endpackage

// File: rtl/crc_tx_dpath.sv
module crc_tx_dpath
  import crc_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobes_t       strb,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serBit
);

  localparam int TOP = CRC_W - 1;

  logic [WORD_W-1:0] shReg;
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  crcStep;
  logic              feedback;

  assign feedback = shReg[WORD_W-1] ^ crcReg[TOP];

  // One stage of the feedback register per generator coefficient.
  for (genvar i = 0; i < CRC_W; i++) begin : g_stage
    if (i == 0) begin : g_lsb
      assign crcStep[i] = POLY[i] & feedback;
    end else begin : g_mid
      assign crcStep[i] = crcReg[i-1] ^ (POLY[i] & feedback);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.loadWord) begin
      shReg <= wordIn;
    end else if (strb.shiftData) begin
      shReg <= {shReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (strb.clearCrc) begin
      crcReg <= '0;
    end else if (strb.shiftData) begin
      crcReg <= crcStep;
    end else if (strb.shiftCrc) begin
      crcReg <= {crcReg[TOP-1:0], 1'b0};
    end
  end

  assign serBit = strb.shiftCrc ? crcReg[TOP] : shReg[WORD_W-1];

endmodule

// File: rtl/crc_tx_ctrl.sv
module crc_tx_ctrl
  import crc_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CRC_W = 16,
  parameter int MAX_WORDS = 255
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        inLast,
  output logic        inReady,
  output logic        serValid,
  output logic        pktDone,
  output crcStrobes_t strb
);

  localparam int LONGEST = (CRC_W > WORD_W) ? CRC_W : WORD_W;
  localparam int BIT_W = $clog2(LONGEST);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam logic [BIT_W-1:0] DATA_END = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] TRAIL_END = BIT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_WORDS);

  txState_t         state, stateNext;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] wordCnt, cntNext;
  logic             endFlag;
  logic             accept;

  assign inReady  = (state == ST_IDLE);
  assign serValid = (state == ST_DATA) || (state == ST_TRAIL);
  assign pktDone  = (state == ST_DONE);
  assign accept   = inValid && inReady;
  assign cntNext  = inFirst ? CNT_W'(1) : wordCnt + CNT_W'(1);

  always_comb begin
    strb.loadWord  = accept;
    strb.clearCrc  = accept && inFirst;
    strb.shiftData = (state == ST_DATA);
    strb.shiftCrc  = (state == ST_TRAIL);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = ST_DATA;
      ST_DATA:  if (bitCnt == DATA_END) stateNext = endFlag ? ST_TRAIL : ST_IDLE;
      ST_TRAIL: if (bitCnt == TRAIL_END) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (stateNext != state) begin
      bitCnt <= '0;
    end else if (serValid) begin
      bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  // Word count and packet-end decision, fixed at acceptance time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt <= '0;
      endFlag <= 1'b0;
    end else if (accept) begin
      wordCnt <= cntNext;
      endFlag <= inLast || (cntNext >= CNT_LIMIT);
    end else if (state == ST_DONE) begin
      wordCnt <= '0;
      endFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/crc_serial_tx.sv
module crc_serial_tx
  import crc_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int MAX_WORDS = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inFirst,
  input  logic              inLast,
  output logic              serOut,
  output logic              serValid,
  output logic              pktDone
);

  crcStrobes_t strb;

  crc_tx_ctrl #(
    .WORD_W(WORD_W), .CRC_W(CRC_W), .MAX_WORDS(MAX_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inLast(inLast), .inReady(inReady), .serValid(serValid),
    .pktDone(pktDone), .strb(strb)
  );

  crc_tx_dpath #(
    .WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIn(inData), .serBit(serOut)
  );

endmodule

// File: rtl/crc_serial_tx_chk.sv
module crc_serial_tx_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic serValid,
  input logic pktDone
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> (!serValid && !pktDone && inReady));

  // R3
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN) (serValid || pktDone) |-> !inReady);

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rstN) (inValid && inReady) |=> serValid);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) pktDone |=> !pktDone);

  // R6
  done_after_bit_chk: assert property (@(posedge clk) disable iff (!rstN) pktDone |-> ($past(serValid) && !serValid));

endmodule

bind crc_serial_tx crc_serial_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .serValid(serValid), .pktDone(pktDone)
);

// File: tb/tb_crc_serial_tx.sv
module tb_crc_serial_tx;

  localparam int W = 8;
  localparam int LIM = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inFirst = 1'b0;
  logic inLast = 1'b0;
  logic [W-1:0] inData = '0;
  logic inReady, serOut, serValid, pktDone;

  crc_serial_tx #(.WORD_W(W), .MAX_WORDS(LIM)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inFirst(inFirst), .inLast(inLast),
    .serOut(serOut), .serValid(serValid), .pktDone(pktDone)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  logic [2:0] expQ[$];   // [2] must follow previous item, [1] done marker, [0] bit
  string tagQ[$];
  logic [15:0] mCrc = '0;
  int mCount = 0;
  bit monOn = 1'b0;
  bit poppedPrev = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelBit(input logic b);
    logic fb;
    fb = b ^ mCrc[15];
    mCrc = {mCrc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endtask

  task automatic pushTrailer(input logic [15:0] c, input string tag);
    for (int i = 15; i >= 0; i--) begin
      expQ.push_back({1'b1, 1'b0, c[i]});
      tagQ.push_back(tag);
    end
    expQ.push_back(3'b110);
    tagQ.push_back("R6");
    mCrc = '0;
    mCount = 0;
  endtask

  // Presents a word and leaves it valid after acceptance (eager source).
  task automatic sendWord(input logic [W-1:0] d, input bit first, input bit last,
                          input string trailTag, input bit useKat = 1'b0,
                          input logic [15:0] kat = 16'h0);
    @(negedge clk);
    inValid = 1'b1;
    inData = d;
    inFirst = first;
    inLast = last;
    if (first) begin
      mCrc = '0;
      mCount = 0;
    end
    mCount++;
    for (int i = W - 1; i >= 0; i--) begin
      expQ.push_back({(i != W - 1), 1'b0, d[i]});
      tagQ.push_back("R2");
      modelBit(d[i]);
    end
    if (last || mCount == LIM) pushTrailer(useKat ? kat : mCrc, trailTag);
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idleBus();
    @(negedge clk);
    inValid = 1'b0;
    inFirst = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    logic [2:0] e;
    string t;
    bit popped;
    popped = 1'b0;
    if (monOn) begin
      if (serValid || pktDone) begin
        check(!inReady, "R3", "ready while busy", inReady, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected output", {serValid, pktDone}, 0);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          popped = 1'b1;
          if (e[1])
            check(pktDone && !serValid, t, "done pulse", {serValid, pktDone}, 1);
          else
            check(serValid && !pktDone && serOut == e[0], t, "serial bit",
                  {pktDone, serOut}, {1'b0, e[0]});
        end
      end else if (poppedPrev && expQ.size() > 0 && expQ[0][2]) begin
        check(1'b0, tagQ[0], "gap in stream", 0, 1);
      end
    end
    poppedPrev = popped;
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(inReady == 1'b1, "R1", "inReady in reset", inReady, 1);
    check(serValid == 1'b0, "R1", "serValid in reset", serValid, 0);
    check(pktDone == 1'b0, "R1", "pktDone in reset", pktDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady && !serValid && !pktDone, "R1", "state after reset",
          {inReady, serValid, pktDone}, 3'b100);
    monOn = 1'b1;

    // Single-word packet: bit order and trailer placement (R2, R5)
    sendWord(8'hA5, 1'b1, 1'b1, "R5");
    idleBus();
    repeat (30) @(negedge clk);

    // Known answer "123456789" -> 0x31C3 (R4)
    for (int k = 0; k < 9; k++)
      sendWord(8'h31 + 8'(k), (k == 0), (k == 8), "R4", 1'b1, 16'h31C3);
    idleBus();
    repeat (5) @(negedge clk);

    // Mid-packet restart via start flag (R7)
    sendWord(8'h11, 1'b1, 1'b0, "R7");
    sendWord(8'h22, 1'b0, 1'b0, "R7");
    sendWord(8'h33, 1'b1, 1'b0, "R7");
    sendWord(8'h44, 1'b0, 1'b1, "R7");
    idleBus();

    // Length limit without last flag (R8), then packet with no start flag (R9)
    for (int k = 0; k < LIM; k++)
      sendWord(8'(8'h0F * k + 3), (k == 0), 1'b0, "R8");
    sendWord(8'h5A, 1'b0, 1'b0, "R9");
    sendWord(8'hC3, 1'b0, 1'b1, "R9");
    idleBus();

    for (int n = 0; n < 200 && expQ.size() != 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5", "expected stream fully produced", expQ.size(), 0);
    check(inReady && !serValid && !pktDone, "R3", "idle after last packet",
          {inReady, serValid, pktDone}, 3'b100);
    summary();
    $finish;
  end

endmodule